// File: doc/BRIEF.md
# Offset-QPSK Spread-Spectrum Baseband Transmitter

This block turns a serial stream of data bits into two shaped baseband sample streams, one in-phase (I) and one quadrature (Q), each for its own DAC. Bits are gathered four at a time into a symbol. Each symbol selects a 32-chip pseudo-noise code. The even chips of that code drive the I branch and the odd chips drive the Q branch. The Q branch lags the I branch by half a branch chip. Every branch chip is shaped into a half-sine pulse of 8 samples, with 8-bit signed amplitude.

All timing follows a single sample enable `smp_en`. One pulse produces one output sample, so a symbol window is 128 samples long. At full rate the enable runs at 8 MHz. This gives 1 Mchip/s per branch, 2 Mchip/s in total, 62.5 ksymbol/s and 250 kb/s. Pulsing the enable less often slows every rate by the same factor. Bits come in through a request/valid handshake.

Two state machines control the block:
- The bit loader has two states, `LD_FILL` and `LD_FULL`. It goes from `LD_FILL` to `LD_FULL` when the fourth bit is accepted. It goes from `LD_FULL` back to `LD_FILL` when the spreader takes the symbol.
- The spreader has two states, `SP_IDLE` and `SP_RUN`. At a window boundary it goes from `SP_IDLE` to `SP_RUN` when a symbol is waiting. At a window boundary it goes from `SP_RUN` to `SP_IDLE` when no symbol is waiting. At any other boundary it stays in its current state.

Top module: `oqpsk_tx`

## Requirements
- R1: While reset is low and just after it, `out_i` and `out_q` are 0, `out_stb` is 0 and `bit_req` is 1.
- R2: `bit_req` stays high until four bits have been accepted, one per cycle with `bit_valid` and `bit_req` both high. The first bit becomes symbol bit 0 and the fourth becomes bit 3. `bit_req` then stays low until the symbol is taken at a window boundary. Bits offered while `bit_req` is low are ignored.
- R3: The code for symbol s is built from a base word B = 0x744AC39B. For s < 8, chip k equals B[(k − 4·s) mod 32]. For s ≥ 8, chip k equals B[(k − 4·(s−8)) mod 32], and every odd-indexed chip is inverted.
- R4: Within a 128-sample window, I sample p carries chip 2·floor(p/8) at pulse phase p mod 8.
- R5: Q carries odd chip 2·floor((p−4)/8)+1 at phase (p−4) mod 8, which is a 4-sample lag. Samples 0..3 of the next window hold phases 4..7 of the previous window's chip 31. If the previous window was idle, these samples are 0.
- R6: A chip of value 1 gives +H[n] and a chip of value 0 gives −H[n], with H = 0, 49, 90, 117, 127, 117, 90, 49 for n = 0..7.
- R7: Each `smp_en` pulse yields exactly one sample, with `out_stb` high in the following cycle. Between strobes `out_i` and `out_q` hold their values.
- R8: Window boundaries fall every 128 samples, counted from reset. A window that starts with no full symbol is idle: I is 0 for the whole window, and Q is 0 apart from the R5 tail.
- R9: Neither output ever takes the most negative code (−128).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| smp_en | input | 1 | Sample enable; its spacing sets all rates |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | `bit_in` holds a valid bit |
| bit_req | output | 1 | Block is requesting data bits |
| out_i | output | SAMP_W | Signed in-phase sample |
| out_q | output | SAMP_W | Signed quadrature sample |
| out_stb | output | 1 | New sample pair present |

## Verification
The assertions check several behaviours on every cycle:
- outputs are held between strobes;
- −128 is never produced;
- I is zero at every chip edge and throughout idle windows;
- the request drops right after the fourth bit;
- a symbol is taken only when one is full.

Other behaviours depend on history and only the bench's scenarios can show them:
- the exact code chips for all 16 symbols;
- the half-chip Q lag and the tail of chip 31 carried into the next window;
- bit ordering into the symbol;
- data offered without a request being ignored;
- recovery after idle windows.

The bench shows these by comparing every sample of both streams with a reference model.

// File: rtl/oqpsk_pkg.sv
package oqpsk_pkg;

    localparam int CHIP_N   = 32;
    localparam int SYM_BITS = 4;
    localparam int SPS      = 8;
    localparam int HALF     = SPS / 2;
    localparam int SYM_SMP  = CHIP_N * SPS / 2;
    localparam int POS_W    = $clog2(SYM_SMP);
    localparam int PH_W     = $clog2(SPS);
    localparam int CIDX_W   = $clog2(CHIP_N);
    localparam int QI_W     = $clog2(HALF + 1);
    localparam int CNT_W    = $clog2(SYM_BITS);

    localparam logic [CHIP_N-1:0] PN_BASE = 32'h744A_C39B;

    // quarter of a half-sine, 7-bit magnitude, phases 0..HALF
    localparam logic [6:0] QWAVE [HALF+1] = '{7'd0, 7'd49, 7'd90, 7'd117, 7'd127};

    typedef enum logic {LD_FILL, LD_FULL} ld_state_t;
    typedef enum logic {SP_IDLE, SP_RUN}  sp_state_t;

    function automatic logic [CHIP_N-1:0] spread_code(input logic [SYM_BITS-1:0] s);
        logic [CHIP_N-1:0] rot;
        int                sh;
        sh  = 4 * int'(s[2:0]);
        rot = (PN_BASE << sh) | (PN_BASE >> (CHIP_N - sh));
        if (s[3]) rot = rot ^ {(CHIP_N/2){2'b10}};
        return rot;
    endfunction

endpackage

// File: rtl/oqpsk_bit_loader.sv
module oqpsk_bit_loader
    import oqpsk_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                bit_valid,
    input  logic                take,
    output logic                bit_req,
    output logic                sym_full,
    output logic [SYM_BITS-1:0] sym
);

    ld_state_t          state, state_nx;
    logic [CNT_W-1:0]   cnt;
    logic               accept;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYM_BITS - 1);

    assign bit_req  = (state == LD_FILL);
    assign sym_full = (state == LD_FULL);
    assign accept   = bit_req && bit_valid;

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_FILL: if (accept && cnt == CNT_LAST) state_nx = LD_FULL;
            LD_FULL: if (take) state_nx = LD_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_FILL;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            sym <= '0;
        end else if (accept) begin
            sym[cnt] <= bit_in;
            cnt      <= cnt + 1'b1;
        end
    end

    // R2
    req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cnt == CNT_LAST) |=> !bit_req);

endmodule

// File: rtl/oqpsk_shaper.sv
module oqpsk_shaper
    import oqpsk_pkg::*;
#(
    parameter int SAMP_W = 8
) (
    input  logic                     en,
    input  logic                     chip,
    input  logic [PH_W-1:0]          phase,
    output logic signed [SAMP_W-1:0] smp
);

    localparam logic [PH_W:0] HALF_L = (PH_W+1)'(HALF);
    localparam logic [PH_W:0] SPS_L  = (PH_W+1)'(SPS);

    logic [PH_W:0]            ph_ext;
    logic [QI_W-1:0]          qi;
    logic signed [SAMP_W-1:0] mag;

    always_comb begin
        ph_ext = {1'b0, phase};
        qi     = (ph_ext <= HALF_L) ? QI_W'(ph_ext) : QI_W'(SPS_L - ph_ext);
        mag    = $signed({{(SAMP_W-7){1'b0}}, QWAVE[qi]}) <<< (SAMP_W - 8);
        if (!en)       smp = '0;
        else if (chip) smp = mag;
        else           smp = -mag;
    end

endmodule

// File: rtl/oqpsk_spreader.sv
module oqpsk_spreader
    import oqpsk_pkg::*;
#(
    parameter int SAMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_en,
    input  logic                     sym_full,
    input  logic [SYM_BITS-1:0]      sym,
    output logic                     take,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_stb
);

    localparam logic [POS_W-1:0] POS_LAST = POS_W'(SYM_SMP - 1);
    localparam logic [POS_W-1:0] POS_HALF = POS_W'(HALF);
    localparam logic signed [SAMP_W-1:0] SMIN = {1'b1, {(SAMP_W-1){1'b0}}};

    sp_state_t           state, state_nx;
    logic [POS_W-1:0]    pos, qpos;
    logic [CHIP_N-1:0]   code;
    logic                tail_on, tail_chip;
    logic                boundary, in_head;
    logic [CIDX_W-1:0]   i_idx, q_idx;
    logic                i_en, q_en, q_chip;
    logic signed [SAMP_W-1:0] i_smp, q_smp;

    assign boundary = smp_en && (pos == POS_LAST);
    assign take     = boundary && sym_full;

    always_comb begin
        state_nx = state;
        unique case (state)
            SP_IDLE: if (take) state_nx = SP_RUN;
            SP_RUN:  if (boundary && !sym_full) state_nx = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SP_IDLE;
        else        state <= state_nx;
    end

    // chip steering: even chips on I, odd chips on Q delayed by HALF samples
    always_comb begin
        qpos    = pos - POS_HALF;
        in_head = (pos < POS_HALF);
        i_idx   = {pos[POS_W-1:PH_W], 1'b0};
        q_idx   = {qpos[POS_W-1:PH_W], 1'b1};
        i_en    = (state == SP_RUN);
        q_en    = in_head ? tail_on : (state == SP_RUN);
        q_chip  = in_head ? tail_chip : code[q_idx];
    end

    oqpsk_shaper #(.SAMP_W(SAMP_W)) i_shape_u (
        .en(i_en), .chip(code[i_idx]), .phase(pos[PH_W-1:0]), .smp(i_smp));

    oqpsk_shaper #(.SAMP_W(SAMP_W)) q_shape_u (
        .en(q_en), .chip(q_chip), .phase(qpos[PH_W-1:0]), .smp(q_smp));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos       <= '0;
            code      <= '0;
            tail_on   <= 1'b0;
            tail_chip <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            out_stb   <= 1'b0;
        end else begin
            out_stb <= smp_en;
            if (smp_en) begin
                out_i <= i_smp;
                out_q <= q_smp;
                pos   <= pos + 1'b1;
            end
            if (boundary) begin
                tail_on   <= (state == SP_RUN);
                tail_chip <= code[CHIP_N-1];
                if (sym_full) code <= spread_code(sym);
            end
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_stb |-> ($stable(out_i) && $stable(out_q)));

    // R9
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_i != SMIN) && (out_q != SMIN));

    // R8
    idle_i_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && state == SP_IDLE) |=> (out_i == '0));

    // R6
    chip_edge_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_en && pos[PH_W-1:0] == '0) |=> (out_i == '0));

endmodule

// File: rtl/oqpsk_tx.sv
module oqpsk_tx
    import oqpsk_pkg::*;
#(
    parameter int SAMP_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     smp_en,
    input  logic                     bit_in,
    input  logic                     bit_valid,
    output logic                     bit_req,
    output logic signed [SAMP_W-1:0] out_i,
    output logic signed [SAMP_W-1:0] out_q,
    output logic                     out_stb
);

    logic                sym_full;
    logic [SYM_BITS-1:0] sym;
    logic                take;

    oqpsk_bit_loader loader_u (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .take(take), .bit_req(bit_req), .sym_full(sym_full), .sym(sym));

    oqpsk_spreader #(.SAMP_W(SAMP_W)) spreader_u (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .sym_full(sym_full),
        .sym(sym), .take(take), .out_i(out_i), .out_q(out_q), .out_stb(out_stb));

    // R2
    take_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> sym_full);

endmodule

// File: tb/oqpsk_tx_tb.sv
module oqpsk_tx_tb_top;

    localparam int NW    = 21;
    localparam int WSMP  = 128;
    localparam int LIMIT = 20000;
    localparam logic [31:0] BASE = 32'h744A_C39B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_en = 1'b0;
    logic bit_in = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_req;
    logic signed [7:0] out_i, out_q;
    logic out_stb;

    int checks = 0;
    int fails  = 0;
    int seen   = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    int win [NW];
    int exp_i_q [$];
    int exp_q_q [$];
    int last_i = 0;
    int last_q = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    oqpsk_tx #(.SAMP_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_en(smp_en), .bit_in(bit_in),
        .bit_valid(bit_valid), .bit_req(bit_req), .out_i(out_i),
        .out_q(out_q), .out_stb(out_stb));

    task automatic check(input string req, input int act, input int expv, input string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    function automatic int hval(input int n);
        return $rtoi(127.0 * $sin(3.14159265358979 * n / 8.0) + 0.5);
    endfunction

    // R3 reference chip rule
    function automatic int chipv(input int s, input int k);
        int r, c;
        r = s % 8;
        c = int'(BASE[(k - 4 * r + 32) % 32]);
        if (s >= 8 && (k % 2) == 1) c = 1 - c;
        return c;
    endfunction

    // R6 reference shape
    function automatic int shape(input int c, input int n);
        return (c == 1) ? hval(n) : -hval(n);
    endfunction

    function automatic int ref_i(input int w, input int p);
        if (win[w] < 0) return 0;
        return shape(chipv(win[w], 2 * (p / 8)), p % 8);
    endfunction

    function automatic int ref_q(input int w, input int p);
        if (p < 4) begin
            if (w > 0 && win[w-1] >= 0) return shape(chipv(win[w-1], 31), p + 4);
            return 0;
        end
        if (win[w] < 0) return 0;
        return shape(chipv(win[w], 2 * ((p - 4) / 8) + 1), (p - 4) % 8);
    endfunction

    // driver of the scoreboard: push every expected sample pair
    task automatic push_expected();
        for (int w = 0; w < NW; w++)
            for (int p = 0; p < WSMP; p++) begin
                exp_i_q.push_back(ref_i(w, p));
                exp_q_q.push_back(ref_q(w, p));
            end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && out_stb) begin
            int ei, eq, w, p;
            string ti, tq;
            w = seen / WSMP;
            p = seen % WSMP;
            ti = (w < NW && win[w] < 0) ? "R8" : "R4";
            tq = (w < NW && win[w] < 0 && p >= 4) ? "R8" : "R5";
            if (exp_i_q.size() == 0) begin
                check("R7", 1, 0, "unexpected strobe");
            end else begin
                ei = exp_i_q.pop_front();
                eq = exp_q_q.pop_front();
                check(ti, int'(out_i), ei, $sformatf("I w%0d p%0d", w, p));
                check(tq, int'(out_q), eq, $sformatf("Q w%0d p%0d", w, p));
            end
            last_i = int'(out_i);
            last_q = int'(out_q);
            seen++;
        end else if (rst_n && seen > 0) begin
            check("R7", int'(out_i), last_i, "I held between strobes");
            check("R7", int'(out_q), last_q, "Q held between strobes");
        end
    end

    task automatic feed(input int s);
        int b;
        b = 0;
        while (b < 4) begin
            @(negedge clk);
            bit_in    = s[b];
            bit_valid = 1'b1;
            if (bit_req) b++;
        end
        @(negedge clk);
        check("R2", int'(bit_req), 0, "request low after four bits");
        bit_in = ~s[0];
        repeat (3) @(negedge clk);
        bit_valid = 1'b0;
        bit_in    = 1'b0;
    endtask

    initial begin
        win[0] = -1;
        for (int s = 0; s < 16; s++) win[s+1] = s;
        win[17] = -1;
        win[18] = -1;
        win[19] = 10;
        win[20] = -1;
        push_expected();

        repeat (3) @(negedge clk);
        check("R1", int'(out_i), 0, "I in reset");
        check("R1", int'(out_q), 0, "Q in reset");
        check("R1", int'(out_stb), 0, "strobe in reset");
        check("R1", int'(bit_req), 1, "request in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_i), 0, "I after reset");
        check("R1", int'(bit_req), 1, "request after reset");

        fork
            begin
                for (int n = 0; n < NW * WSMP; n++) begin
                    @(negedge clk); smp_en = 1'b1;
                    @(negedge clk); smp_en = 1'b0;
                end
            end
            begin
                for (int w = 1; w < NW; w++)
                    if (win[w] >= 0) begin
                        wait (seen >= (w - 1) * WSMP + 8);
                        feed(win[w]);
                    end
            end
        join

        repeat (4) @(negedge clk);
        check("R7", seen, NW * WSMP, "one strobe per enable");
        check("R7", exp_i_q.size(), 0, "scoreboard drained");
        check("R2", int'(bit_req), 1, "request high while idle");
        done = 1'b1;
    end

    initial begin
        wait (done || cyc >= LIMIT);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule